// File: doc/BRIEF.md
# Real-Time Clock Alarm Comparator and Interrupt Flag Register

This block sits beside the time-keeping counters of a real-time clock. It compares the running seconds, minutes and hours against three programmed alarm values, and it keeps a sticky interrupt flag register. The register records three kinds of event: a periodic tick, an alarm hit, and the end of a time update. A summary bit in the same register, mirrored on the interrupt output, is raised when any recorded event has its enable bit set in the control byte.

The alarm is evaluated only on an update-ended pulse, and all three fields must agree at that moment. An alarm byte whose two top bits are both one matches any value of its field, so an alarm can fire every second, every minute or every hour. The flag register is read-to-clear: the bus logic strobes a read input and every flag drops on the next clock edge. If a new event arrives in the same cycle as the read, that event's flag stays set. Time and alarm bytes use one number format, so the compare is a plain equality.

Top module: `rtc_alm_irq`

## Requirements
- R1: A field matches when its alarm byte equals its current time byte. The alarm flag (flag byte bit 5) is set one clock after an update pulse only when all three fields match.
- R2: An alarm byte with bits 7 and 6 both 1 (0xC0 to 0xFF) matches any value of its time field.
- R3: An update pulse while any field mismatches leaves the alarm flag unchanged. Without an update pulse, matching fields never set the alarm flag.
- R4: An update pulse sets the update-ended flag (bit 4) one clock later. A periodic tick sets the periodic flag (bit 6) one clock later.
- R5: The summary bit (bit 7) is 1 when the periodic flag is set with control bit 6, the alarm flag with control bit 5, or the update flag with control bit 4. It follows changes of the control byte in the same cycle. The interrupt output equals the summary bit.
- R6: A read strobe clears bits 6, 5 and 4 on the next clock edge.
- R7: When a read strobe and a flag event occur in the same cycle, the flag of that event is set after the edge and all others are clear.
- R8: After reset the flag byte is 0x00 and the interrupt is low. Bits 3 to 0 of the flag byte always read 0.
- R9: A set flag stays set across cycles without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_now | input | 8 | Current seconds |
| min_now | input | 8 | Current minutes |
| hr_now | input | 8 | Current hours |
| sec_alarm | input | 8 | Seconds alarm byte |
| min_alarm | input | 8 | Minutes alarm byte |
| hr_alarm | input | 8 | Hours alarm byte |
| ctrl_byte | input | 8 | Control byte; bits 6, 5, 4 enable periodic, alarm and update interrupts |
| tick_pulse | input | 1 | One-cycle periodic tick |
| update_pulse | input | 1 | One-cycle end-of-update marker |
| flag_read | input | 1 | Read strobe of the flag register; clears it |
| flag_byte | output | 8 | Flag register: bit 7 summary, 6 periodic, 5 alarm, 4 update, 3..0 zero |
| irq_o | output | 1 | Interrupt request, equal to the summary bit |

## Verification
The hardest case to reach is the collision of a read strobe with new events in one cycle. Only that case shows whether clear or set takes priority, and whether the summary re-forms from the surviving flag alone. The stimulus first raises all three flags. It then drives the read together with a tick, and later together with an update whose fields all match, and checks that only the new flags survive. Wildcard alarm bytes are combined with a single mismatching field, so the bench can tell an all-field match from a per-field one.

// File: rtl/rtc_alm_pkg.sv
package rtc_alm_pkg;

    // flag byte bit positions (decoded by the bus side)
    localparam int FLAG_W  = 8;
    localparam int SUM_BIT = 7;
    localparam int PF_BIT  = 6;
    localparam int AF_BIT  = 5;
    localparam int UF_BIT  = 4;

    // event flags
    typedef struct packed {
        logic pf;
        logic af;
        logic uf;
    } irq_flags_t;

    // interrupt enables taken from the control byte
    typedef struct packed {
        logic pie;
        logic aie;
        logic uie;
    } irq_en_t;

endpackage

// File: rtl/rtc_alm_field_cmp.sv
module rtc_alm_field_cmp #(
    parameter int FIELD_W = 8
) (
    input  logic [FIELD_W-1:0] now_val,
    input  logic [FIELD_W-1:0] alarm_val,
    output logic               hit
);
    logic wild;

    always_comb begin
        // both top bits set: field is a wildcard
        wild = &alarm_val[FIELD_W-1:FIELD_W-2];
        hit  = wild | (alarm_val == now_val);
    end
endmodule

// File: rtl/rtc_alm_match.sv
module rtc_alm_match #(
    parameter int FIELD_W    = 8,
    parameter int NUM_FIELDS = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_FIELDS-1:0][FIELD_W-1:0]  now_vals,
    input  logic [NUM_FIELDS-1:0][FIELD_W-1:0]  alarm_vals,
    output logic                                all_hit
);
    logic [NUM_FIELDS-1:0] field_hit;
    logic [NUM_FIELDS-1:0] field_wild;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
        rtc_alm_field_cmp #(.FIELD_W(FIELD_W)) cmp_i (
            .now_val   (now_vals[g]),
            .alarm_val (alarm_vals[g]),
            .hit       (field_hit[g])
        );
        assign field_wild[g] = &alarm_vals[g][FIELD_W-1:FIELD_W-2];
    end

    always_comb all_hit = &field_hit;

    // R2: wildcard bytes in every field always give a match
    assert_wild_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (&field_wild) |-> all_hit);

    // R1: exact equality of every field gives a match
    assert_equal_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (now_vals == alarm_vals) |-> all_hit);
endmodule

// File: rtl/rtc_alm_flags.sv
module rtc_alm_flags
    import rtc_alm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       upd,
    input  logic       alarm_hit,
    input  logic       rd,
    input  irq_en_t    en,
    output irq_flags_t flags,
    output logic       summary
);
    typedef struct packed {
        irq_flags_t f;
    } state_t;

    state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (rd) state_d.f = '0;
        // events are applied after the clear so they win
        if (tick) state_d.f.pf = 1'b1;
        if (upd) begin
            state_d.f.uf = 1'b1;
            if (alarm_hit) state_d.f.af = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    always_comb begin
        flags   = state_q.f;
        summary = (state_q.f.pf & en.pie) |
                  (state_q.f.af & en.aie) |
                  (state_q.f.uf & en.uie);
    end

    // R1: update with all fields matching raises the alarm flag
    assert_alarm_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && alarm_hit) |=> state_q.f.af);

    // R3: alarm flag only rises after an update with a match
    assert_alarm_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q.f.af) |-> $past(upd && alarm_hit));

    // R4: tick and update pulses set their flags
    assert_tick_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> state_q.f.pf);
    assert_upd_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> state_q.f.uf);

    // R6: a lone read clears every flag
    assert_read_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !tick && !upd) |=> (state_q.f == '0));

    // R7: read with a tick leaves only the periodic flag
    assert_event_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && tick && !upd) |=> (state_q.f == 3'b100));

    // R5: summary needs a recorded flag
    assert_summary_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
        summary |-> (state_q.f != '0));
endmodule

// File: rtl/rtc_alm_irq.sv
module rtc_alm_irq
    import rtc_alm_pkg::*;
#(
    parameter int FIELD_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FIELD_W-1:0] sec_now,
    input  logic [FIELD_W-1:0] min_now,
    input  logic [FIELD_W-1:0] hr_now,
    input  logic [FIELD_W-1:0] sec_alarm,
    input  logic [FIELD_W-1:0] min_alarm,
    input  logic [FIELD_W-1:0] hr_alarm,
    input  logic [7:0]         ctrl_byte,
    input  logic               tick_pulse,
    input  logic               update_pulse,
    input  logic               flag_read,
    output logic [7:0]         flag_byte,
    output logic               irq_o
);
    localparam int NUM_FIELDS = 3;

    logic [NUM_FIELDS-1:0][FIELD_W-1:0] now_vals;
    logic [NUM_FIELDS-1:0][FIELD_W-1:0] alarm_vals;
    logic       all_hit;
    irq_en_t    en;
    irq_flags_t flags;
    logic       summary;

    always_comb begin
        now_vals   = {hr_now, min_now, sec_now};
        alarm_vals = {hr_alarm, min_alarm, sec_alarm};
        en.pie     = ctrl_byte[PF_BIT];
        en.aie     = ctrl_byte[AF_BIT];
        en.uie     = ctrl_byte[UF_BIT];
    end

    rtc_alm_match #(.FIELD_W(FIELD_W), .NUM_FIELDS(NUM_FIELDS)) match_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .now_vals   (now_vals),
        .alarm_vals (alarm_vals),
        .all_hit    (all_hit)
    );

    rtc_alm_flags flags_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_pulse),
        .upd       (update_pulse),
        .alarm_hit (all_hit),
        .rd        (flag_read),
        .en        (en),
        .flags     (flags),
        .summary   (summary)
    );

    always_comb begin
        flag_byte          = '0;
        flag_byte[SUM_BIT] = summary;
        flag_byte[PF_BIT]  = flags.pf;
        flag_byte[AF_BIT]  = flags.af;
        flag_byte[UF_BIT]  = flags.uf;
        irq_o              = summary;
    end

    // R9: flags hold without a read
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_read && (flag_byte[6:4] != 3'b000)) |=>
        ((flag_byte[6:4] & $past(flag_byte[6:4])) == $past(flag_byte[6:4])));
endmodule

// File: tb/rtc_alm_irq_tb_top.sv
`timescale 1ns/1ps
module rtc_alm_irq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sec_now = 0, min_now = 0, hr_now = 0;
    logic [7:0] sec_alarm = 0, min_alarm = 0, hr_alarm = 0;
    logic [7:0] ctrl_byte = 0;
    logic       tick_pulse = 0, update_pulse = 0, flag_read = 0;
    logic [7:0] flag_byte;
    logic       irq_o;

    int n_checks = 0;
    int n_fail   = 0;

    // model state
    logic m_pf = 0, m_af = 0, m_uf = 0;

    logic [7:0] q_exp[$];
    string      q_tag[$];

    always #10 clk = ~clk;

    rtc_alm_irq dut_i (
        .clk(clk), .rst_n(rst_n),
        .sec_now(sec_now), .min_now(min_now), .hr_now(hr_now),
        .sec_alarm(sec_alarm), .min_alarm(min_alarm), .hr_alarm(hr_alarm),
        .ctrl_byte(ctrl_byte), .tick_pulse(tick_pulse),
        .update_pulse(update_pulse), .flag_read(flag_read),
        .flag_byte(flag_byte), .irq_o(irq_o)
    );

    function automatic logic fld_ok(input logic [7:0] a, input logic [7:0] c);
        return (a >= 8'hC0) || (a == c);
    endfunction

    function automatic logic [7:0] exp_byte();
        logic s;
        s = (m_pf & ctrl_byte[6]) | (m_af & ctrl_byte[5]) | (m_uf & ctrl_byte[4]);
        return {s, m_pf, m_af, m_uf, 4'b0000};
    endfunction

    task automatic compare(input logic [7:0] exp, input string tag);
        n_checks++;
        if (flag_byte !== exp || irq_o !== exp[7]) begin
            n_fail++;
            $display("FAIL %s: flag_byte=%02h irq=%b expected flag_byte=%02h irq=%b",
                     tag, flag_byte, irq_o, exp, exp[7]);
        end
    endtask

    task automatic set_fields(input logic [7:0] s, m, h, as, am, ah);
        @(negedge clk); #2;
        sec_now = s; min_now = m; hr_now = h;
        sec_alarm = as; min_alarm = am; hr_alarm = ah;
    endtask

    // driver: one cycle of stimulus, pushes the expected result
    task automatic step(input logic tk, input logic up, input logic rd,
                        input logic [7:0] ctl, input string tag);
        logic hit;
        @(negedge clk); #2;
        tick_pulse = tk; update_pulse = up; flag_read = rd; ctrl_byte = ctl;
        hit = fld_ok(sec_alarm, sec_now) && fld_ok(min_alarm, min_now) &&
              fld_ok(hr_alarm, hr_now);
        @(posedge clk); #1;
        if (rd) begin m_pf = 0; m_af = 0; m_uf = 0; end
        if (tk) m_pf = 1;
        if (up) begin m_uf = 1; if (hit) m_af = 1; end
        q_exp.push_back(exp_byte());
        q_tag.push_back(tag);
        tick_pulse = 0; update_pulse = 0; flag_read = 0;
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (q_exp.size() > 0) compare(q_exp.pop_front(), q_tag.pop_front());
        end
    end

    // watchdog
    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;
        @(negedge clk);
        compare(8'h00, "R8 reset state");

        // periodic tick, enables off
        step(1, 0, 0, 8'h00, "R4 tick sets periodic flag");
        step(0, 0, 0, 8'h00, "R9 periodic flag sticky");
        step(0, 0, 0, 8'h40, "R5 periodic enable raises summary");
        step(0, 0, 1, 8'h40, "R6 read clears flags");

        // update with a mismatching seconds field
        set_fields(8'h10, 8'h20, 8'h05, 8'h11, 8'h20, 8'h05);
        step(0, 1, 0, 8'h20, "R3 mismatch sets only update flag");
        step(0, 0, 0, 8'h10, "R5 update enable raises summary");
        step(0, 0, 1, 8'h00, "R6 read clears update flag");

        // matching fields but no update pulse
        set_fields(8'h11, 8'h20, 8'h05, 8'h11, 8'h20, 8'h05);
        step(0, 0, 0, 8'h20, "R3 match without update no alarm");
        step(0, 1, 0, 8'h00, "R1 exact match sets alarm flag");
        step(0, 0, 0, 8'h20, "R5 alarm enable raises summary");
        step(0, 0, 1, 8'h20, "R6 read clears alarm flag");

        // wildcards
        set_fields(8'h37, 8'h42, 8'h13, 8'hC0, 8'hFF, 8'hD5);
        step(0, 1, 0, 8'h20, "R2 all wildcard bytes match");
        step(0, 0, 1, 8'h00, "R6 read after wildcard alarm");
        set_fields(8'h37, 8'h42, 8'h13, 8'hC0, 8'hBF, 8'hC3);
        step(0, 1, 0, 8'h20, "R2 byte 0xBF is not wildcard, no alarm");
        step(0, 0, 1, 8'h00, "R6 clear");

        // collisions
        set_fields(8'h01, 8'h02, 8'h03, 8'h01, 8'h02, 8'h03);
        step(1, 1, 0, 8'h70, "R4 all three flags set");
        step(0, 0, 1, 8'h70, "R6 read clears all three");
        step(1, 1, 0, 8'h00, "R9 raise all again");
        step(1, 0, 1, 8'h70, "R7 read with tick keeps periodic");
        step(0, 1, 1, 8'h30, "R7 read with update keeps alarm and update");
        step(0, 0, 0, 8'h40, "R5 enables only for absent flag");
        step(0, 0, 0, 8'hFF, "R8 low bits read zero with all control bits");
        step(0, 0, 1, 8'hFF, "R6 final clear");

        while (q_exp.size() > 0) @(posedge clk);
        @(negedge clk); @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule